// File: doc/BRIEF.md
# Slow-Clock Timer Register Write Bridge

This block connects a processor-clock register interface to an 8-bit timer that runs on a separate, slow and unrelated timer clock. The processor writes one of three targets: the counter, the compare value or the control word. Each target has its own holding register. The written value crosses into the timer domain and is committed to its destination after two rising edges of the timer clock. While that transfer is in flight, the target's busy bit is set, and this bit can be read from the processor side. A fresh write to a busy target is dropped, and a sticky error bit records the drop.

The timer side counts, compares and raises a compare-match event. A match is not reported around counter or compare updates. The processor never reads the counter directly. It reads a copy held in its own clock domain, and that copy is refreshed only after each rising edge of the timer clock. The only output toward interrupt logic is the compare-match flag, which the processor clears by pulsing a clear input.

Top module: `tmr_wr_bridge`

## Requirements
- R1: A write strobe with target select 0 (counter), 1 (compare) or 2 (control) stores the data in that target's holding register. The value is committed to the timer-domain destination on the second rising timer-clock edge after the write. Select 3 addresses no target.
- R2: The three targets transfer independently. A write to one target while another target is busy is accepted and does not set the error bit. Both values are committed.
- R3: busy_o bit n belongs to target n. It is 0 after reset. It reads 1 in the cycle after an accepted write and returns to 0 a few processor cycles after the commit.
- R4: No compare match is raised at the timer edge that commits a counter or compare write, nor at the timer edge that follows it. Writing the counter to the current compare value therefore produces no match.
- R5: A write to a target whose busy bit is 1 is ignored, and the pending value is kept. The write sets wr_err_o, which stays at 1 until clr_i bit 1 is pulsed.
- R6: cnt_o is the processor-domain copy of the counter. It is 0 after reset and changes only after a rising timer-clock edge. While the timer clock is stopped, cnt_o keeps its last value.
- R7: While enabled, the counter increases by one on each rising timer-clock edge and wraps from 255 to 0.
- R8: match_o is set when, at a timer edge outside the window of R4, the counter is enabled and the counter equals the compare value. match_o stays at 1 until clr_i bit 0 is pulsed.
- R9: Bit 0 of the control word enables the counter. After reset the counter holds its value until a control write with bit 0 set has been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| tclk_i | input | 1 | Slow timer clock |
| wr_en_i | input | 1 | Write strobe, one processor cycle |
| wr_sel_i | input | 2 | Target: 0 counter, 1 compare, 2 control |
| wr_data_i | input | 8 | Write data |
| clr_i | input | 2 | Bit 0 clears match_o, bit 1 clears wr_err_o |
| busy_o | output | 3 | Per-target update-busy bits |
| wr_err_o | output | 1 | Sticky flag for an ignored write |
| cnt_o | output | 8 | Processor-domain counter copy |
| match_o | output | 1 | Compare-match flag |

## Verification
The checker assumes that the processor clock runs more than four times faster than the timer clock. Only under that condition is the counter copy sampled while it is stable, and only then does every toggle crossing land before the next one. The checker also assumes that write strobes last a single processor cycle. The stimulus uses a 100 MHz processor clock and a 73 ns timer clock, a ratio above seven that is not an integer. It holds every strobe for one cycle and stops the timer clock only between edges.

// File: rtl/tmr_bridge_pkg.sv
package tmr_bridge_pkg;
  localparam int NUM_TGT = 3;
  typedef enum logic [1:0] {
    TGT_CNT  = 2'd0,
    TGT_CMP  = 2'd1,
    TGT_CTL  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else begin
      q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/tmr_wr_chan.sv
module tmr_wr_chan #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         tclk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic         rej_o,
  output logic [W-1:0] hold_o,
  output logic         commit_o
);
  logic req_tgl, ack_sync;
  logic req_s1, req_s2;

  // processor side
  assign busy_o = req_tgl ^ ack_sync;
  assign rej_o  = wr_i & busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tgl <= 1'b0;
      hold_o  <= '0;
    end else if (wr_i && !busy_o) begin
      req_tgl <= ~req_tgl;
      hold_o  <= data_i;
    end
  end

  // timer side: hold_o is stable until the ack returns
  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
    end else begin
      req_s1 <= req_tgl;
      req_s2 <= req_s1;
    end
  end

  assign commit_o = req_s1 ^ req_s2;

  tmr_sync #(.W(1), .STAGES(2)) i_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_s2),
    .q_o   (ack_sync)
  );
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_bridge_pkg::*;
#(
  parameter int W      = 8,
  parameter int EN_BIT = 0
) (
  input  logic                      tclk_i,
  input  logic                      rst_ni,
  input  logic [NUM_TGT-1:0]        commit_i,
  input  logic [NUM_TGT-1:0][W-1:0] hold_i,
  output logic [W-1:0]              cnt_o,
  output logic                      match_tgl_o,
  output logic                      rd_tgl_o
);
  logic [W-1:0] cmp_q, ctl_q;
  logic         inh_q, inhibit, en;

  assign en      = ctl_q[EN_BIT];
  assign inhibit = commit_i[TGT_CNT] | commit_i[TGT_CMP] | inh_q;

  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= '0;
      cmp_q       <= '0;
      ctl_q       <= '0;
      inh_q       <= 1'b0;
      match_tgl_o <= 1'b0;
      rd_tgl_o    <= 1'b0;
    end else begin
      rd_tgl_o <= ~rd_tgl_o;
      inh_q    <= commit_i[TGT_CNT] | commit_i[TGT_CMP];
      if (commit_i[TGT_CMP]) cmp_q <= hold_i[TGT_CMP];
      if (commit_i[TGT_CTL]) ctl_q <= hold_i[TGT_CTL];
      if (en && !inhibit && cnt_o == cmp_q) match_tgl_o <= ~match_tgl_o;
      if (commit_i[TGT_CNT]) cnt_o <= hold_i[TGT_CNT];
      else if (en)           cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_wr_bridge.sv
module tmr_wr_bridge
  import tmr_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EN_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tclk_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        clr_i,
  output logic [NUM_TGT-1:0] busy_o,
  output logic              wr_err_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              match_o
);
  logic [NUM_TGT-1:0]             rej, commit;
  logic [NUM_TGT-1:0][DATA_W-1:0] hold;
  logic [DATA_W-1:0]              cnt_t;
  logic                           match_tgl, rd_tgl;
  logic [1:0]                     ev_sync, ev_prev;
  logic                           rd_stb, match_stb;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_chan
    tmr_wr_chan #(.W(DATA_W)) i_chan (
      .clk_i   (clk_i),
      .tclk_i  (tclk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (wr_sel_i == 2'(g))),
      .data_i  (wr_data_i),
      .busy_o  (busy_o[g]),
      .rej_o   (rej[g]),
      .hold_o  (hold[g]),
      .commit_o(commit[g])
    );
  end

  tmr_core #(.W(DATA_W), .EN_BIT(EN_BIT)) i_core (
    .tclk_i     (tclk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .hold_i     (hold),
    .cnt_o      (cnt_t),
    .match_tgl_o(match_tgl),
    .rd_tgl_o   (rd_tgl)
  );

  tmr_sync #(.W(2), .STAGES(2)) i_ev_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({match_tgl, rd_tgl}),
    .q_o   (ev_sync)
  );

  assign rd_stb    = ev_sync[0] ^ ev_prev[0];
  assign match_stb = ev_sync[1] ^ ev_prev[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_prev  <= '0;
      cnt_o    <= '0;
      match_o  <= 1'b0;
      wr_err_o <= 1'b0;
    end else begin
      ev_prev <= ev_sync;
      // cnt_t is quiet here given the clock ratio
      if (rd_stb) cnt_o <= cnt_t;
      if (match_stb)     match_o <= 1'b1;
      else if (clr_i[0]) match_o <= 1'b0;
      if (|rej)          wr_err_o <= 1'b1;
      else if (clr_i[1]) wr_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_wr_bridge_chk.sv
module tmr_wr_bridge_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [1:0]        clr_i,
  input logic [2:0]        busy_o,
  input logic              wr_err_o,
  input logic [DATA_W-1:0] cnt_o,
  input logic              match_o,
  input logic              rd_stb
);
  AST_BUSY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i != 2'd3) |=> busy_o[$past(wr_sel_i)]) else $error("busy"); // R3
  AST_ERR_ON_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i != 2'd3 && busy_o[wr_sel_i]) |=> wr_err_o) else $error("err set"); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_err_o && !clr_i[1]) |=> wr_err_o) else $error("err sticky"); // R5
  AST_READ_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb |=> $stable(cnt_o)) else $error("readback"); // R6
  AST_MATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !clr_i[0]) |=> match_o) else $error("match sticky"); // R8
endmodule

bind tmr_wr_bridge tmr_wr_bridge_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .wr_sel_i(wr_sel_i),
  .clr_i   (clr_i),
  .busy_o  (busy_o),
  .wr_err_o(wr_err_o),
  .cnt_o   (cnt_o),
  .match_o (match_o),
  .rd_stb  (rd_stb)
);

// File: tb/test_tmr_wr_bridge.sv
module test_tmr_wr_bridge;
  logic       clk = 1'b0, tclk = 1'b0, tclk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0, clr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] busy;
  logic       wr_err, match;
  logic [7:0] cnt;
  int total = 0, bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] VEC [4] = '{8'h00, 8'h5A, 8'hFF, 8'h01};

  always #5 clk = ~clk;
  always #36.5 if (tclk_run) tclk = ~tclk;

  tmr_wr_bridge i_tmr_wr_bridge (
    .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .clr_i(clr),
    .busy_o(busy), .wr_err_o(wr_err), .cnt_o(cnt), .match_o(match)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] c);
    @(negedge clk); clr = c;
    @(negedge clk); clr = 2'd0;
  endtask

  task automatic wait_idle(input int t, input string req);
    int n = 0;
    while (busy[t] && n < 100) begin @(negedge clk); n++; end
    check(req, busy[t], 0);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge tclk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev, snap;
    int n;
    repeat (4) @(negedge clk);
    check("R3 reset busy", busy, 0);
    check("R6 reset cnt", cnt, 0);
    check("R8 reset match", match, 0);
    check("R5 reset err", wr_err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table: counter disabled, write then read back
    for (int i = 0; i < 4; i++) begin
      write(2'd0, VEC[i]);
      check("R3 busy set", busy[0], 1);
      wait_idle(0, "R3 busy clear");
      tick(2);
      check("R1 counter commit", cnt, VEC[i]);
    end

    // ignored write while busy
    write(2'd0, 8'h11);
    write(2'd0, 8'h22);
    check("R5 err set", wr_err, 1);
    wait_idle(0, "R3 busy clear");
    tick(2);
    check("R5 pending kept", cnt, 8'h11);
    check("R5 err sticky", wr_err, 1);
    pulse_clr(2'b10);
    check("R5 err clear", wr_err, 0);

    // independent targets
    write(2'd0, 8'h30);
    write(2'd1, 8'h40);
    check("R2 both busy", busy[1:0], 2'b11);
    check("R2 no err", wr_err, 0);
    wait_idle(0, "R2 cnt idle");
    wait_idle(1, "R2 cmp idle");
    tick(2);
    check("R2 cnt value", cnt, 8'h30);

    // counter held until enable committed
    tick(10);
    check("R9 held disabled", cnt, 8'h30);
    check("R8 no match disabled", match, 0);
    write(2'd2, 8'h01);
    wait_idle(2, "R9 ctl idle");
    tick(2);
    check("R9 advancing", int'(cnt != 8'h30), 1);

    // match at 0x40
    n = 0;
    while (!match && n < 60) begin tick(1); n++; end
    check("R8 match set", match, 1);
    check("R8 match near cmp", int'(cnt >= 8'h40 && cnt <= 8'h43), 1);
    tick(3);
    check("R8 match held", match, 1);
    pulse_clr(2'b01);
    check("R8 match clear", match, 0);

    // counter write equal to compare: suppressed
    write(2'd0, 8'h40);
    wait_idle(0, "R4 idle");
    tick(10);
    check("R4 no match on write", match, 0);

    // wrap
    write(2'd0, 8'hFC);
    wait_idle(0, "R7 idle");
    tick(1);
    prev = cnt;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      check("R7 increment", cnt, 8'(prev + 8'd1));
      prev = cnt;
    end
    check("R7 wrapped", int'(cnt < 8'h10), 1);

    // timer clock stopped
    @(negedge tclk);
    tclk_run = 1'b0;
    repeat (10) @(negedge clk);
    snap = cnt;
    repeat (60) @(negedge clk);
    check("R6 stable while stopped", cnt, snap);
    tclk_run = 1'b1;
    tick(1);
    check("R6 refresh after edge", cnt, 8'(snap + 8'd1));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule